// File: doc/BRIEF.md
# Oversampled Serial Pixel Link Receiver

This block sits behind a fast deserializer that samples a single serial line from a digital focal-plane array several times per bit. Each core clock it receives one word of samples, and together those samples cover exactly one bit period. The serial link delay is fixed but not known in advance, so neither the bit boundary nor the packet boundary is known. The block treats each sample position inside the word as its own candidate bit stream. It then looks for a fixed synchronization word on every candidate at once.

When the synchronization word appears, the block looks at the run of sample positions that matched. It keeps the one in the middle of that run, which lies farthest from the bit edges. The same event also marks where the packet starts. The block then counts the payload words out of the chosen stream and checks that the next synchronization word arrives exactly where it should. Only after enough good synchronization words in a row does it declare lock and start delivering payload words. Each delivered word carries a valid pulse, and the first word of every packet is also flagged. If a synchronization word is missing, the block drops lock and searches again.

Top module: `osr_sync_rx`

## Requirements
- R1: While reset is held, and after it is released, `word_vld_o`, `pkt_start_o` and `locked_o` are low until lock is reached.
- R2: Input sample `smp_i[p]` is the p-th sample in time order within a bit period, where index 0 is the earliest. Sample position p taken from successive words forms candidate stream p.
- R3: The synchronization word is 16'hE4B1 and is sent most significant bit first. During search, the block finds the contiguous run of matching sample positions across two consecutive sample words and takes the centre of that run as the sampling phase. For a line whose first sample of each bit cell still shows the previous bit, this is the third sample of the cell.
- R4: After a synchronization word, a packet carries N_WORDS (default 4) payload words of 14 bits each, sent most significant bit first. They are delivered on `word_o` in arrival order.
- R5: Lock is declared only after LOCK_HITS (default 2) synchronization words have been seen in a row, each exactly one packet length after the previous one. No payload word is delivered while `locked_o` is low, and every delivered word belongs to a packet that follows a locking synchronization word.
- R6: `pkt_start_o` is high together with `word_vld_o` on the first payload word of each delivered packet, and only on that word.
- R7: If the synchronization word is absent at the expected position, `locked_o` falls, the payload of that packet is not delivered, and the search restarts.
- R8: Reception is correct for any static line delay, whether it is a fraction of a bit period or a whole number of bits.
- R9: `word_vld_o` is a single-cycle pulse per word and is never high on two consecutive cycles.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Core clock, one sample word per cycle |
| rst_n | input | 1 | Active-low synchronous reset |
| smp_i | input | OSR (4) | Oversampled line samples for one bit period, index 0 earliest |
| word_o | output | WORD_W (14) | Recovered payload word |
| word_vld_o | output | 1 | One-cycle strobe for `word_o` |
| pkt_start_o | output | 1 | Marks the first payload word of a packet |
| locked_o | output | 1 | High while packet alignment is locked |

## Verification
A line model sends the packets at a range of static delays. These include every sub-bit sample offset and several whole-bit shifts. The line also repeats the previous bit in the first sample of each bit cell. A phase pick next to a bit edge therefore corrupts the payload, while a pick at the centre of the run does not. Packet streams with one synchronization word spoiled separate three behaviours: locking on a single sighting, locking on the required consecutive pair, and dropping lock and recovering after a miss. Each of these yields a different set of delivered packets. Payload words vary with the packet and word index, so an error in word order, bit order or packet-start flagging shows up as a wrong value.

// File: rtl/osr_rx_pkg.sv
package osr_rx_pkg;

    typedef enum logic [1:0] {
        ST_SEARCH  = 2'd0,
        ST_CONFIRM = 2'd1,
        ST_LOCKED  = 2'd2
    } rx_state_e;

endpackage

// File: rtl/osr_phase_match.sv
module osr_phase_match #(
    parameter int                OSR       = 4,
    parameter int                SYNC_W    = 16,
    parameter logic [SYNC_W-1:0] SYNC_WORD = 16'hE4B1
) (
    input  logic           clk,
    input  logic           rst_n,
    input  logic [OSR-1:0] smp_i,
    output logic [OSR-1:0] hit_o
);

    typedef struct packed {
        logic [OSR-1:0][SYNC_W-1:0] sh;
    } match_regs_t;

    match_regs_t r_q, r_d;

    always_comb begin
        r_d = r_q;
        for (int p = 0; p < OSR; p++) begin
            r_d.sh[p] = {r_q.sh[p][SYNC_W-2:0], smp_i[p]};
        end
    end

    // one comparator per candidate sampling phase
    for (genvar g = 0; g < OSR; g++) begin : g_cmp
        assign hit_o[g] = (r_d.sh[g] == SYNC_WORD);
    end

    always_ff @(posedge clk) begin
        if (!rst_n) r_q <= '0;
        else        r_q <= r_d;
    end

endmodule

// File: rtl/osr_phase_pick.sv
module osr_phase_pick #(
    parameter int OSR = 4,
    localparam int VW = 2 * OSR,
    localparam int IW = $clog2(VW) + 1,
    localparam int PW = (OSR > 1) ? $clog2(OSR) : 1
) (
    input  logic           clk,
    input  logic           rst_n,
    input  logic           enable_i,
    input  logic [OSR-1:0] hit_i,
    output logic           pick_o,
    output logic [PW-1:0]  phase_o,
    output logic           late_o
);

    typedef struct packed {
        logic [OSR-1:0] prev;
        logic [OSR-1:0] prev2;
    } pick_regs_t;

    pick_regs_t r_q, r_d;
    logic [VW-1:0] win;
    logic [IW-1:0] lo, hi, ctr;
    logic [IW:0]   sum;

    always_comb begin
        r_d       = r_q;
        r_d.prev  = hit_i;
        r_d.prev2 = r_q.prev;
        win = {hit_i, r_q.prev};
        lo  = IW'(VW - 1);
        hi  = '0;
        for (int i = VW - 1; i >= 0; i--) begin
            if (win[i]) lo = IW'(i);
        end
        for (int i = 0; i < VW; i++) begin
            if (win[i]) hi = IW'(i);
        end
        sum    = {1'b0, lo} + {1'b0, hi};
        ctr    = sum[IW:1];
        late_o = (ctr >= IW'(OSR));
        phase_o = late_o ? PW'(ctr - IW'(OSR)) : PW'(ctr);
        // decide one cycle after the first matching word of a run
        pick_o = enable_i && (|r_q.prev) && !(|r_q.prev2);
    end

    always_ff @(posedge clk) begin
        if (!rst_n) r_q <= '0;
        else        r_q <= r_d;
    end

    // R3
    single_pick_chk: assert property (@(posedge clk) disable iff (!rst_n)
        pick_o |=> !pick_o);

endmodule

// File: rtl/osr_frame_track.sv
module osr_frame_track
    import osr_rx_pkg::*;
#(
    parameter int                OSR       = 4,
    parameter int                SYNC_W    = 16,
    parameter int                WORD_W    = 14,
    parameter int                N_WORDS   = 4,
    parameter int                LOCK_HITS = 2,
    parameter logic [SYNC_W-1:0] SYNC_WORD = 16'hE4B1,
    localparam int PW = (OSR > 1) ? $clog2(OSR) : 1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [OSR-1:0]    smp_i,
    input  logic              pick_i,
    input  logic [PW-1:0]     phase_i,
    input  logic              late_i,
    output logic              searching_o,
    output logic [WORD_W-1:0] word_o,
    output logic              word_vld_o,
    output logic              pkt_start_o,
    output logic              locked_o
);

    localparam int DATA_BITS  = N_WORDS * WORD_W;
    localparam int FRAME_BITS = DATA_BITS + SYNC_W;
    localparam int POS_W      = $clog2(FRAME_BITS);
    localparam int BC_W       = $clog2(WORD_W);
    localparam int WC_W       = $clog2(N_WORDS + 1);
    localparam int HC_W       = $clog2(LOCK_HITS + 1);

    typedef struct packed {
        rx_state_e         st;
        logic [PW-1:0]     phase;
        logic [POS_W-1:0]  pos;
        logic [BC_W-1:0]   bitc;
        logic [WC_W-1:0]   wrd;
        logic [HC_W-1:0]   hits;
        logic [WORD_W-1:0] acc;
        logic [SYNC_W-1:0] ssh;
        logic [WORD_W-1:0] word;
        logic              vld;
        logic              sop;
    } trk_regs_t;

    trk_regs_t r_q, r_d;
    logic srch, take, b;
    logic [PW-1:0]    sel;
    logic [POS_W-1:0] cpos;
    logic [BC_W-1:0]  cbitc;
    logic [WC_W-1:0]  cwrd;

    always_comb begin
        r_d     = r_q;
        r_d.vld = 1'b0;
        r_d.sop = 1'b0;
        srch  = (r_q.st == ST_SEARCH);
        sel   = srch ? phase_i : r_q.phase;
        b     = smp_i[sel];
        take  = !srch || (pick_i && !late_i);
        cpos  = srch ? '0 : r_q.pos;
        cbitc = srch ? '0 : r_q.bitc;
        cwrd  = srch ? '0 : r_q.wrd;

        if (srch && pick_i) begin
            r_d.phase = phase_i;
            r_d.pos   = '0;
            r_d.bitc  = '0;
            r_d.wrd   = '0;
            r_d.hits  = HC_W'(1);
            r_d.st    = (LOCK_HITS <= 1) ? ST_LOCKED : ST_CONFIRM;
        end

        if (take) begin
            if (int'(cpos) < DATA_BITS) begin
                r_d.acc = {r_q.acc[WORD_W-2:0], b};
                r_d.pos = cpos + POS_W'(1);
                if (int'(cbitc) == WORD_W - 1) begin
                    r_d.bitc = '0;
                    r_d.wrd  = cwrd + WC_W'(1);
                    if (r_q.st == ST_LOCKED) begin
                        r_d.vld  = 1'b1;
                        r_d.sop  = (cwrd == '0);
                        r_d.word = {r_q.acc[WORD_W-2:0], b};
                    end
                end else begin
                    r_d.bitc = cbitc + BC_W'(1);
                end
            end else begin
                r_d.ssh = {r_q.ssh[SYNC_W-2:0], b};
                if (int'(cpos) == FRAME_BITS - 1) begin
                    r_d.pos  = '0;
                    r_d.bitc = '0;
                    r_d.wrd  = '0;
                    if (r_d.ssh == SYNC_WORD) begin
                        if (r_q.st == ST_CONFIRM) begin
                            r_d.hits = r_q.hits + HC_W'(1);
                            if (int'(r_q.hits) + 1 >= LOCK_HITS) r_d.st = ST_LOCKED;
                        end
                    end else begin
                        r_d.st   = ST_SEARCH;
                        r_d.hits = '0;
                    end
                end else begin
                    r_d.pos = cpos + POS_W'(1);
                end
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            r_q    <= '0;
            r_q.st <= ST_SEARCH;
        end else begin
            r_q <= r_d;
        end
    end

    assign searching_o = (r_q.st == ST_SEARCH);
    assign locked_o    = (r_q.st == ST_LOCKED);
    assign word_o      = r_q.word;
    assign word_vld_o  = r_q.vld;
    assign pkt_start_o = r_q.sop;

    // R5
    vld_needs_lock_chk: assert property (@(posedge clk) disable iff (!rst_n)
        word_vld_o |-> locked_o);

    // R9
    vld_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
        word_vld_o |=> !word_vld_o);

    // R7
    drop_to_search_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(locked_o) |-> searching_o);

endmodule

// File: rtl/osr_sync_rx.sv
module osr_sync_rx #(
    parameter int                OSR       = 4,
    parameter int                SYNC_W    = 16,
    parameter int                WORD_W    = 14,
    parameter int                N_WORDS   = 4,
    parameter int                LOCK_HITS = 2,
    parameter logic [SYNC_W-1:0] SYNC_WORD = 16'hE4B1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [OSR-1:0]    smp_i,
    output logic [WORD_W-1:0] word_o,
    output logic              word_vld_o,
    output logic              pkt_start_o,
    output logic              locked_o
);

    localparam int PW = (OSR > 1) ? $clog2(OSR) : 1;

    logic [OSR-1:0] hit;
    logic           pick, late, searching;
    logic [PW-1:0]  phase;

    osr_phase_match #(.OSR(OSR), .SYNC_W(SYNC_W), .SYNC_WORD(SYNC_WORD)) u_match (
        .clk(clk), .rst_n(rst_n), .smp_i(smp_i), .hit_o(hit)
    );

    osr_phase_pick #(.OSR(OSR)) u_pick (
        .clk(clk), .rst_n(rst_n), .enable_i(searching), .hit_i(hit),
        .pick_o(pick), .phase_o(phase), .late_o(late)
    );

    osr_frame_track #(
        .OSR(OSR), .SYNC_W(SYNC_W), .WORD_W(WORD_W), .N_WORDS(N_WORDS),
        .LOCK_HITS(LOCK_HITS), .SYNC_WORD(SYNC_WORD)
    ) u_track (
        .clk(clk), .rst_n(rst_n), .smp_i(smp_i), .pick_i(pick),
        .phase_i(phase), .late_i(late), .searching_o(searching),
        .word_o(word_o), .word_vld_o(word_vld_o),
        .pkt_start_o(pkt_start_o), .locked_o(locked_o)
    );

    // R6
    sop_with_vld_chk: assert property (@(posedge clk) disable iff (!rst_n)
        pkt_start_o |-> word_vld_o);

endmodule

// File: tb/osr_sync_rx_tb.sv
`timescale 1ns/1ps
module osr_sync_rx_tb;

    localparam int OSR = 4, SW = 16, WW = 14, NW = 4;
    localparam logic [15:0] SYNC = 16'hE4B1;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic [OSR-1:0] smp = '0;
    logic [WW-1:0] word_o;
    logic word_vld_o, pkt_start_o, locked_o;

    always #2 clk = ~clk;

    osr_sync_rx #(.OSR(OSR), .SYNC_W(SW), .WORD_W(WW), .N_WORDS(NW),
                  .LOCK_HITS(2), .SYNC_WORD(SYNC)) u_dut (
        .clk(clk), .rst_n(rst_n), .smp_i(smp), .word_o(word_o),
        .word_vld_o(word_vld_o), .pkt_start_o(pkt_start_o), .locked_o(locked_o)
    );

    int total = 0, bad = 0;
    logic bits [0:1023];
    int nbits = 0, dly = 0;
    logic [WW-1:0] expw [0:127];
    int nexp = 0;
    logic [WW-1:0] gotw [0:127];
    logic gots [0:127];
    int ngot = 0, b2b = 0, unlocked_vld = 0, falls = 0;
    logic pv = 1'b0, pl = 1'b0, mon_en = 1'b0;

    always @(negedge clk) begin
        if (mon_en) begin
            if (word_vld_o) begin
                if (ngot < 128) begin
                    gotw[ngot] = word_o;
                    gots[ngot] = pkt_start_o;
                end
                ngot++;
                if (pv) b2b++;
                if (!locked_o) unlocked_vld++;
            end
            if (pl && !locked_o) falls++;
        end
        pv = word_vld_o;
        pl = locked_o;
    end

    task automatic check(input bit ok, input string req, input string what,
                         input int act, input int expv);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s %s: actual=%0d expected=%0d", req, what, act, expv);
        end
    endtask

    function automatic logic [WW-1:0] dword(input int f, input int w, input int seed);
        int v;
        v = (f * 37 + w * 11 + seed * 5 + 3) * 181;
        return v[WW-1:0];
    endfunction

    task automatic build(input int nfr, input int badfr, input int seed);
        logic [15:0] s;
        logic [WW-1:0] d;
        nbits = 0;
        nexp  = 0;
        for (int i = 0; i < 24; i++) begin bits[nbits] = 1'b0; nbits++; end
        for (int f = 0; f < nfr; f++) begin
            s = (f == badfr) ? (SYNC ^ 16'h0100) : SYNC;
            for (int i = 15; i >= 0; i--) begin bits[nbits] = s[i]; nbits++; end
            for (int w = 0; w < NW; w++) begin
                d = dword(f, w, seed);
                for (int i = WW - 1; i >= 0; i--) begin bits[nbits] = d[i]; nbits++; end
            end
        end
    endtask

    task automatic expect_frame(input int f, input int seed);
        for (int w = 0; w < NW; w++) begin
            expw[nexp] = dword(f, w, seed);
            nexp++;
        end
    endtask

    // line model: first sample of each bit cell still shows the previous bit
    function automatic logic samp(input int n);
        int m, bi, o;
        logic cur, prv;
        m = n - dly;
        if (m < 0) return 1'b0;
        bi = m / 4;
        o  = m % 4;
        cur = (bi < nbits) ? bits[bi] : 1'b0;
        prv = (bi >= 1 && bi - 1 < nbits) ? bits[bi-1] : 1'b0;
        return (o == 0) ? prv : cur;
    endfunction

    task automatic run_stream();
        int ncyc;
        @(negedge clk);
        rst_n  = 1'b0;
        smp    = '0;
        mon_en = 1'b0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        ngot = 0; b2b = 0; unlocked_vld = 0; falls = 0;
        mon_en = 1'b1;
        ncyc = (dly + nbits * 4) / 4 + 40;
        for (int c = 0; c < ncyc; c++) begin
            @(negedge clk);
            for (int p = 0; p < OSR; p++) smp[p] = samp(c * 4 + p);
        end
        @(negedge clk);
        mon_en = 1'b0;
    endtask

    task automatic compare(input string tag);
        int lim;
        check(ngot == nexp, "R5", {tag, " delivered word count"}, ngot, nexp);
        lim = (ngot < nexp) ? ngot : nexp;
        if (lim > 128) lim = 128;
        for (int i = 0; i < lim; i++) begin
            check(gotw[i] == expw[i], "R4", {tag, " payload word"}, int'(gotw[i]), int'(expw[i]));
            check(gots[i] == ((i % NW) == 0), "R6", {tag, " packet start flag"},
                  int'(gots[i]), int'((i % NW) == 0));
        end
        check(b2b == 0, "R9", {tag, " back-to-back strobes"}, b2b, 0);
        check(unlocked_vld == 0, "R5", {tag, " strobe while unlocked"}, unlocked_vld, 0);
    endtask

    task automatic t_reset();
        @(negedge clk);
        rst_n = 1'b0;
        repeat (3) @(negedge clk);
        check(word_vld_o == 1'b0, "R1", "strobe in reset", int'(word_vld_o), 0);
        check(pkt_start_o == 1'b0, "R1", "start flag in reset", int'(pkt_start_o), 0);
        check(locked_o == 1'b0, "R1", "lock in reset", int'(locked_o), 0);
        rst_n = 1'b1;
        repeat (4) @(negedge clk);
        check(locked_o == 1'b0 && word_vld_o == 1'b0, "R1", "idle after reset",
              int'({locked_o, word_vld_o}), 0);
    endtask

    // R2 R3 R8: clean packets under a given static delay
    task automatic t_clean(input int d, input int seed);
        dly = d;
        build(6, -1, seed);
        for (int f = 1; f < 6; f++) expect_frame(f, seed);
        run_stream();
        compare($sformatf("R8 delay=%0d", d));
        check(falls == 1, "R3", "single lock loss at end of stream", falls, 1);
    endtask

    // R7: missing sync word in a locked stream
    task automatic t_drop();
        dly = 6;
        build(8, 3, 9);
        expect_frame(1, 9); expect_frame(2, 9);
        expect_frame(5, 9); expect_frame(6, 9); expect_frame(7, 9);
        run_stream();
        compare("R7 drop");
        check(falls == 2, "R7", "lock losses", falls, 2);
    endtask

    // R5: one sighting is not enough to lock
    task automatic t_two();
        dly = 11;
        build(6, 1, 4);
        expect_frame(3, 4); expect_frame(4, 4); expect_frame(5, 4);
        run_stream();
        compare("R5 pair");
    endtask

    logic done = 1'b0;

    initial begin
        #(200000 * 4);
        if (!done) begin
            total++;
            bad++;
            $display("FAIL watchdog: actual=%0d expected=%0d", 1, 0);
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        t_reset();
        t_clean(0, 1);
        t_clean(1, 2);
        t_clean(2, 3);
        t_clean(3, 4);
        t_clean(7, 5);
        t_clean(13, 6);
        t_clean(22, 7);
        t_drop();
        t_two();
        done = 1'b1;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule